// File: doc/BRIEF.md
# Paged Audio Controller Register Bank

This block is the 32-bit register bank of a three-channel audio controller. The controller has two playback channels and one capture channel. The host reaches the bank through a byte-addressed 256-byte I/O window. Each access carries a size (byte, halfword or word) and a byte address. Write data and read data are right-justified. Narrow writes to the control and serial-control registers merge into the addressed byte lanes and leave the other lanes as they were.

A 4-bit page register extends the window. When the low address byte falls in 0x30..0x3F, the page value, shifted left by 8, is placed above it to form a 12-bit effective offset. Through that window the host reaches the frame address and frame count registers of each channel.

Each channel has a completion pulse input. A pulse latches a pending bit, but only while that channel's interrupt enable is set. The status word shows the three pending bits and a summary bit, and a single level interrupt follows the summary bit. Turning an enable off also drops that channel's pending bit.

Top module: `audreg_bank`

## Requirements
- R1: After reset, control reads 0x00000001, status reads 0x00000060, and page, codec, serial control, sample counts and frame registers read 0. The interrupt is low.
- R2: A read request returns its data on rsp_rdata, with rsp_valid high, in the cycle after the request. Byte and halfword reads are zero-extended.
- R3: Any write to offset 0x0C stores only bits 3:0 of the written value into the page register.
- R4: If the low address byte is 0x30..0x3F, the effective offset is {page, address}. Frame address registers sit at 0xC30 (playback 1), 0xC38 (playback 2) and 0xD30 (capture), and frame counts at 0xC34, 0xC3C and 0xD34. Frame registers are written by word writes only and read as words; a halfword read of a frame count at +0 or +2 returns its low or high half.
- R5: Byte and halfword writes to control (0x00) or serial control (0x20) replace only the addressed 8-bit or 16-bit lane.
- R6: Status bits 2, 1 and 0 are the pending bits of playback 1, playback 2 and capture. Bits 6:5 read as 1. Bit 31 is the OR of the three pending bits, and irq is high exactly when any of them is set.
- R7: A serial-control write that takes a channel's enable from 1 to 0 clears that channel's pending bit at the same clock edge. The enables are bits 8, 9 and 10 for playback 1, playback 2 and capture.
- R8: A completion pulse sets the pending bit only if the channel's enable is 1 before the edge. If an enable-dropping write arrives in the same cycle, the clear wins.
- R9: Reads of unmapped effective offsets, including the unused paged slots 0xD38 and 0xD3C, return 0xFFFFFFFF. A byte read of offset 0x1B returns 5.
- R10: The sample-count registers sit at 0x24, 0x28 and 0x2C. A halfword or word write sets only the low 16 bits, which hold the total. The upper 16 bits hold the current count, read by a halfword at offset +2. A completion pulse copies the total into the current count.
- R11: A halfword or word write to 0x10 replaces the codec register with the zero-extended written value.
- R12: A halfword write at an odd address, or a word write at an address that is not a multiple of 4, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 8 | Byte address within the window |
| req_wdata | input | 32 | Right-justified write data |
| chan_done | input | 3 | Completion pulses: bit 0 playback 1, bit 1 playback 2, bit 2 capture |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Right-justified read data |
| irq | output | 1 | Level interrupt |

## Verification
The in-line assertions check these rules on every cycle:
- a pending bit rises only after an enabled completion pulse;
- an enable drop clears the pending bit at the next edge;
- irq agrees with the summary status bit;
- a narrow control write leaves the other lanes untouched;
- a misaligned write leaves every register as it was;
- read data follows a read request by one cycle.

Some behaviour only the bench's scenarios can show. These are the absolute reset and register values, the page-to-frame-register mapping, the all-ones and legacy read values, the reload of the current count, and the clear-over-set priority when an enable drop and a pulse meet in one cycle.

// File: rtl/audreg_pkg.sv
package audreg_pkg;
  localparam int DW  = 32;
  localparam int AW  = 8;
  localparam int PGW = 4;
  localparam int EAW = AW + PGW;
  localparam int NCH = 3;
  localparam int HW  = DW / 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  localparam logic [EAW-1:0] OFF_CTRL   = 12'h000;
  localparam logic [EAW-1:0] OFF_STAT   = 12'h004;
  localparam logic [EAW-1:0] OFF_PAGE   = 12'h00C;
  localparam logic [EAW-1:0] OFF_CODEC  = 12'h010;
  localparam logic [EAW-1:0] OFF_LEGACY = 12'h01B;
  localparam logic [EAW-1:0] OFF_SCTL   = 12'h020;

  // Effective offset: the paged window 0x30..0x3F takes the page above it.
  function automatic logic [EAW-1:0] eff_addr(input logic [AW-1:0] a, input logic [PGW-1:0] pg);
    if (a[7:4] == 4'h3) return {pg, a};
    return {{PGW{1'b0}}, a};
  endfunction

  function automatic logic aligned(input acc_size_e sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: return 1'b1;
      SZ_HALF: return !lo[0];
      SZ_WORD: return lo == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_mask(input acc_size_e sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF << {lo, 3'b000};
      SZ_HALF: return 32'h0000_FFFF << {lo[1], 4'b0000};
      SZ_WORD: return '1;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old, input logic [DW-1:0] wd,
                                               input acc_size_e sz, input logic [1:0] lo);
    logic [DW-1:0] spread;
    case (sz)
      SZ_BYTE: spread = {4{wd[7:0]}};
      SZ_HALF: spread = {2{wd[15:0]}};
      default: spread = wd;
    endcase
    return (old & ~lane_mask(sz, lo)) | (spread & lane_mask(sz, lo));
  endfunction

  function automatic logic [EAW-1:0] scnt_off(input int i);
    return EAW'(36 + 4 * i);
  endfunction

  function automatic logic [EAW-1:0] faddr_off(input int i);
    return (i < 2) ? EAW'(12'hC30 + 8 * i) : 12'hD30;
  endfunction

  function automatic logic [EAW-1:0] fcnt_off(input int i);
    return faddr_off(i) + 12'd4;
  endfunction

  // Status pending order: bit2 playback 1, bit1 playback 2, bit0 capture.
  function automatic logic [DW-1:0] status_word(input logic [2:0] pend);
    return {|pend, 23'b0, 8'h60 | {5'b0, pend}};
  endfunction
endpackage

// File: rtl/audreg_irq.sv
module audreg_irq
  import audreg_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] en_now_i,
  input  logic [N-1:0] en_new_i,
  input  logic         en_wr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] set_evt_o,
  output logic [N-1:0] drop_evt_o
);
  assign set_evt_o  = done_i & en_now_i;
  assign drop_evt_o = en_wr_i ? (en_now_i & ~en_new_i) : '0;

  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= (pend_o | set_evt_o) & ~drop_evt_o;
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    a_r7_drop_clears: assert property (@(posedge clk) disable iff (rst)
      drop_evt_o[k] |=> !pend_o[k]);
    a_r8_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_o[k]) |-> $past(done_i[k] && en_now_i[k]));
    a_r8_set_latches: assert property (@(posedge clk) disable iff (rst)
      (set_evt_o[k] && !drop_evt_o[k]) |=> pend_o[k]);
  end
endmodule

// File: rtl/audreg_chan.sv
module audreg_chan
  import audreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_we_i,
  input  logic [HW-1:0] cnt_i,
  input  logic          done_i,
  input  logic          fa_we_i,
  input  logic          fc_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] scount_o,
  output logic [DW-1:0] faddr_o,
  output logic [DW-1:0] fcnt_o
);
  logic [HW-1:0] total_q, cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      cur_q   <= '0;
      faddr_o <= '0;
      fcnt_o  <= '0;
    end else begin
      if (cnt_we_i) total_q <= cnt_i;
      if (done_i)   cur_q   <= total_q;
      if (fa_we_i)  faddr_o <= wdata_i;
      if (fc_we_i)  fcnt_o  <= wdata_i;
    end
  end

  assign scount_o = {cur_q, total_q};

  a_r10_reload: assert property (@(posedge clk) disable iff (rst)
    done_i |=> cur_q == $past(total_q));
endmodule

// File: rtl/audreg_bank.sv
module audreg_bank
  import audreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  input  logic [2:0]  chan_done,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        irq
);
  logic [DW-1:0]  ctrl_q, sctl_q, codec_q, sctl_new, mask, stat_word, rd;
  logic [PGW-1:0] page_q;
  logic [EAW-1:0] ea;
  acc_size_e      sz;
  logic           ok, wr, rd_req, ctrl_we, sctl_we, page_we, codec_we;
  logic [NCH-1:0] cnt_we, fa_we, fc_we, pend, set_evt, drop_evt;
  logic [DW-1:0]  scount [NCH];
  logic [DW-1:0]  faddr  [NCH];
  logic [DW-1:0]  fcnt   [NCH];

  assign sz       = acc_size_e'(req_size);
  assign ea       = eff_addr(req_addr, page_q);
  assign ok       = aligned(sz, ea[1:0]);
  assign wr       = req_valid && req_write && ok;
  assign rd_req   = req_valid && !req_write;
  assign mask     = lane_mask(sz, ea[1:0]);
  assign ctrl_we  = wr && (ea[EAW-1:2] == OFF_CTRL[EAW-1:2]);
  assign sctl_we  = wr && (ea[EAW-1:2] == OFF_SCTL[EAW-1:2]);
  assign page_we  = wr && (ea == OFF_PAGE);
  assign codec_we = wr && (ea == OFF_CODEC) && (sz != SZ_BYTE);
  assign sctl_new = sctl_we ? lane_merge(sctl_q, req_wdata, sz, ea[1:0]) : sctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= 32'h0000_0001;
      sctl_q  <= '0;
      codec_q <= '0;
      page_q  <= '0;
    end else begin
      if (ctrl_we)  ctrl_q  <= lane_merge(ctrl_q, req_wdata, sz, ea[1:0]);
      if (sctl_we)  sctl_q  <= sctl_new;
      if (codec_we) codec_q <= (sz == SZ_HALF) ? {16'b0, req_wdata[15:0]} : req_wdata;
      if (page_we)  page_q  <= req_wdata[PGW-1:0];
    end
  end

  audreg_irq #(.N(NCH)) u_irq (
    .clk(clk), .rst(rst), .done_i(chan_done),
    .en_now_i(sctl_q[10:8]), .en_new_i(sctl_new[10:8]), .en_wr_i(sctl_we),
    .pend_o(pend), .set_evt_o(set_evt), .drop_evt_o(drop_evt)
  );

  assign stat_word = status_word({pend[0], pend[1], pend[2]});
  assign irq       = |pend;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cnt_we[i] = wr && (sz != SZ_BYTE) && (ea == scnt_off(i));
    assign fa_we[i]  = wr && (sz == SZ_WORD) && (ea == faddr_off(i));
    assign fc_we[i]  = wr && (sz == SZ_WORD) && (ea == fcnt_off(i));
    audreg_chan u_ch (
      .clk(clk), .rst(rst), .cnt_we_i(cnt_we[i]), .cnt_i(req_wdata[HW-1:0]),
      .done_i(chan_done[i]), .fa_we_i(fa_we[i]), .fc_we_i(fc_we[i]),
      .wdata_i(req_wdata), .scount_o(scount[i]), .faddr_o(faddr[i]), .fcnt_o(fcnt[i])
    );
  end

  always_comb begin
    rd = '1;
    case (sz)
      SZ_BYTE: begin
        if (ea[EAW-1:2] == OFF_CTRL[EAW-1:2]) rd = {24'b0, 8'(ctrl_q >> {ea[1:0], 3'b000})};
        if (ea[EAW-1:2] == OFF_STAT[EAW-1:2]) rd = {24'b0, 8'(stat_word >> {ea[1:0], 3'b000})};
        if (ea == OFF_PAGE)   rd = {28'b0, page_q};
        if (ea == OFF_LEGACY) rd = 32'd5;
      end
      SZ_HALF: begin
        for (int i = 0; i < NCH; i++) begin
          if (ea == scnt_off(i) + 12'd2) rd = {16'b0, scount[i][31:16]};
          if (ea == fcnt_off(i))         rd = {16'b0, fcnt[i][15:0]};
          if (ea == fcnt_off(i) + 12'd2) rd = {16'b0, fcnt[i][31:16]};
        end
      end
      SZ_WORD: begin
        if (ea == OFF_CTRL)  rd = ctrl_q;
        if (ea == OFF_STAT)  rd = stat_word;
        if (ea == OFF_PAGE)  rd = {28'b0, page_q};
        if (ea == OFF_CODEC) rd = codec_q;
        if (ea == OFF_SCTL)  rd = sctl_q;
        for (int i = 0; i < NCH; i++) begin
          if (ea == scnt_off(i))  rd = scount[i];
          if (ea == faddr_off(i)) rd = faddr[i];
          if (ea == fcnt_off(i))  rd = fcnt[i];
        end
      end
      default: rd = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd;
    end
  end

  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);
  a_r5_lane_keep: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> ((ctrl_q & ~$past(mask)) == ($past(ctrl_q) & ~$past(mask))));
  a_r6_irq_summary: assert property (@(posedge clk) disable iff (rst)
    irq == stat_word[31]);
  a_r3_page_low_bits: assert property (@(posedge clk) disable iff (rst)
    page_we |=> page_q == $past(req_wdata[PGW-1:0]));
  a_r12_misaligned_ignored: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !ok) |=> ($stable(ctrl_q) && $stable(sctl_q) && $stable(codec_q) && $stable(page_q)));
endmodule

// File: tb/sim_audreg_bank.sv
module sim_audreg_bank;
  localparam int PERIOD = 10;
  localparam logic [1:0] B = 2'd0, H = 2'd1, W = 2'd2;
  localparam int NV = 35;
  // Entry: {requirement, is_read, size, address, data-or-expected}
  localparam logic [46:0] VEC [NV] = '{
    {4'd1, 1'b1, W, 8'h00, 32'h0000_0001},  // R1
    {4'd1, 1'b1, W, 8'h04, 32'h0000_0060},  // R1
    {4'd1, 1'b1, W, 8'h20, 32'h0000_0000},  // R1
    {4'd1, 1'b1, W, 8'h0C, 32'h0000_0000},  // R1
    {4'd1, 1'b1, W, 8'h10, 32'h0000_0000},  // R1
    {4'd5, 1'b0, B, 8'h02, 32'h0000_00AB},  // R5
    {4'd5, 1'b1, W, 8'h00, 32'h00AB_0001},
    {4'd5, 1'b0, H, 8'h02, 32'h0000_1234},
    {4'd5, 1'b1, W, 8'h00, 32'h1234_0001},
    {4'd5, 1'b1, B, 8'h03, 32'h0000_0012},
    {4'd3, 1'b0, W, 8'h0C, 32'hFFFF_FFFC},  // R3
    {4'd3, 1'b1, W, 8'h0C, 32'h0000_000C},
    {4'd4, 1'b0, W, 8'h30, 32'h1111_2222},  // R4
    {4'd4, 1'b0, W, 8'h38, 32'h3333_4444},
    {4'd4, 1'b0, W, 8'h34, 32'h0005_0007},
    {4'd4, 1'b1, H, 8'h36, 32'h0000_0005},
    {4'd4, 1'b1, H, 8'h34, 32'h0000_0007},
    {4'd3, 1'b0, B, 8'h0C, 32'h0000_000D},
    {4'd4, 1'b0, W, 8'h30, 32'h5555_6666},
    {4'd4, 1'b1, W, 8'h30, 32'h5555_6666},
    {4'd9, 1'b1, W, 8'h38, 32'hFFFF_FFFF},  // R9
    {4'd3, 1'b0, B, 8'h0C, 32'h0000_000C},
    {4'd4, 1'b1, W, 8'h30, 32'h1111_2222},
    {4'd4, 1'b1, W, 8'h38, 32'h3333_4444},
    {4'd9, 1'b1, B, 8'h1B, 32'h0000_0005},
    {4'd9, 1'b1, W, 8'h14, 32'hFFFF_FFFF},
    {4'd10, 1'b0, W, 8'h28, 32'hABCD_1234}, // R10
    {4'd10, 1'b1, W, 8'h28, 32'h0000_1234},
    {4'd11, 1'b0, H, 8'h10, 32'h0000_BEEF}, // R11
    {4'd11, 1'b1, W, 8'h10, 32'h0000_BEEF},
    {4'd12, 1'b0, H, 8'h01, 32'h0000_5555}, // R12
    {4'd12, 1'b1, W, 8'h00, 32'h1234_0001},
    {4'd9, 1'b1, H, 8'h05, 32'hFFFF_FFFF},
    {4'd5, 1'b0, B, 8'h21, 32'h0000_0007},
    {4'd5, 1'b1, W, 8'h20, 32'h0000_0700}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [7:0] req_addr = 8'h00;
  logic [31:0] req_wdata = '0;
  logic [2:0] chan_done = 3'b000;
  logic rsp_valid, irq;
  logic [31:0] rsp_rdata;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  audreg_bank u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .chan_done(chan_done), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr_op(input logic [1:0] s, input logic [7:0] a, input logic [31:0] d, input logic [2:0] dn);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = s; req_addr = a; req_wdata = d; chan_done = dn;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; chan_done = 3'b000;
  endtask

  task automatic rd_op(input logic [1:0] s, input logic [7:0] a, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = s; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    q = rsp_rdata;
  endtask

  task automatic pulse(input logic [2:0] dn);
    @(negedge clk); chan_done = dn;
    @(negedge clk); chan_done = 3'b000;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [31:0] q;
    do_reset();
    chk("R1 irq low after reset", {31'b0, irq}, 32'd0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42]) begin
        rd_op(VEC[i][41:40], VEC[i][39:32], q);
        chk($sformatf("R%0d table row %0d", VEC[i][46:43], i), q, VEC[i][31:0]);
      end else begin
        wr_op(VEC[i][41:40], VEC[i][39:32], VEC[i][31:0], 3'b000);
      end
    end
    // R2: response valid in the cycle after a read request
    @(negedge clk); req_valid = 1'b1; req_write = 1'b0; req_size = W; req_addr = 8'h00;
    @(negedge clk); req_valid = 1'b0;
    chk("R2 rsp_valid after read", {31'b0, rsp_valid}, 32'd1);
    chk("R2 read data", rsp_rdata, 32'h1234_0001);
    @(negedge clk);
    chk("R2 rsp_valid drops", {31'b0, rsp_valid}, 32'd0);
    // R8 / R6: enabled pulse on playback 1 sets status bit 2
    pulse(3'b001);
    rd_op(W, 8'h04, q);
    chk("R8 playback1 pending set", q, 32'h8000_0064);
    chk("R6 irq high", {31'b0, irq}, 32'd1);
    // R8: capture disabled, its pulse is ignored
    wr_op(B, 8'h21, 32'h03, 3'b000);
    pulse(3'b100);
    rd_op(W, 8'h04, q);
    chk("R8 disabled capture pulse ignored", q, 32'h8000_0064);
    // R10: playback 2 pulse reloads current count
    pulse(3'b010);
    rd_op(W, 8'h04, q);
    chk("R6 two pending", q, 32'h8000_0066);
    rd_op(H, 8'h2A, q);
    chk("R10 current count reloaded", q, 32'h0000_1234);
    rd_op(W, 8'h28, q);
    chk("R10 full sample count", q, 32'h1234_1234);
    // R7: dropping playback 1 enable clears its pending bit
    wr_op(B, 8'h21, 32'h02, 3'b000);
    rd_op(W, 8'h04, q);
    chk("R7 playback1 cleared", q, 32'h8000_0062);
    chk("R6 irq still high", {31'b0, irq}, 32'd1);
    wr_op(B, 8'h21, 32'h00, 3'b000);
    rd_op(W, 8'h04, q);
    chk("R7 playback2 cleared", q, 32'h0000_0060);
    chk("R6 irq low", {31'b0, irq}, 32'd0);
    // R8: drop and pulse in the same cycle, clear wins
    wr_op(B, 8'h21, 32'h02, 3'b000);
    wr_op(B, 8'h21, 32'h00, 3'b010);
    rd_op(W, 8'h04, q);
    chk("R8 clear wins over same-cycle pulse", q, 32'h0000_0060);
    chk("R8 irq low after tie", {31'b0, irq}, 32'd0);
    // R1: reset in the middle of a run
    wr_op(W, 8'h20, 32'h0000_0100, 3'b000);
    pulse(3'b001);
    do_reset();
    rd_op(W, 8'h00, q); chk("R1 control after reset", q, 32'h0000_0001);
    rd_op(W, 8'h04, q); chk("R1 status after reset", q, 32'h0000_0060);
    rd_op(W, 8'h0C, q); chk("R1 page after reset", q, 32'h0000_0000);
    rd_op(W, 8'h28, q); chk("R1 sample count after reset", q, 32'h0000_0000);
    rd_op(W, 8'h30, q); chk("R9 page 0 window unmapped", q, 32'hFFFF_FFFF);
    chk("R1 irq low after second reset", {31'b0, irq}, 32'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule